// File: doc/BRIEF.md
# Command Processor Execute ALU

This block is the execute stage arithmetic unit of a small command-processor microcontroller. Each cycle it takes a decoded operation, a first register operand and a second operand, and combinationally produces a 32-bit result. The second operand is either a second register or a 16-bit unsigned immediate zero-extended to 32 bits. Which one is used depends on the instruction form. In the immediate form the operation code comes from the instruction header. In the two-register form a 5-bit selector field in the low bits of the instruction picks the operation.

One flip-flop holds a carry/borrow bit, so a 64-bit add or subtract can be split over two instructions. The low word is done with a plain add or subtract and the high word with the chaining variant, which consumes the stored bit. The flag is written only on the clock edge that ends an issued instruction (`in_valid` high) of one of the four add/subtract operations.

Top module: `cpalu_core`

## Requirements
- R1: When `two_reg` is 1 the operation is `sub_opc` and the second operand is `src2`. When `two_reg` is 0 the operation is `hdr_opc` and the second operand is `imm` zero-extended to 32 bits. Operation codes: NOP 0x00, ADD 0x01, ADDHI 0x02, SUB 0x03, SUBHI 0x04, AND 0x05, OR 0x06, XOR 0x07, NOT 0x08, SHL 0x09, USHR 0x0a, ISHR 0x0b, ROT 0x0c, MUL8 0x0d, MIN 0x0e, MAX 0x0f, CMP 0x10, MOVI 0x11, MSB 0x14.
- R2: ADD and SUB give the 32-bit wrapped sum or difference of the two operands. On the next rising edge with `in_valid` high, `carry` takes the carry-out of ADD, or for SUB a borrow that is 1 when the first operand is unsigned-less than the second.
- R3: ADDHI returns first + second + `carry`, and SUBHI returns first − second − `carry`, both wrapped to 32 bits. With `in_valid` high, each one loads its own carry-out or borrow into `carry` on the next edge.
- R4: `carry` is 0 after reset. It does not change on edges where `in_valid` is low, nor after any operation other than the four add/subtract codes.
- R5: AND, OR and XOR are bitwise on the two operands. NOT returns the bitwise inverse of the second operand whatever `src1` holds.
- R6: SHL, USHR (zero fill), ISHR (sign fill) and ROT (left rotate, with bits wrapping into bit 0) shift `src1` by the low 5 bits of the second operand.
- R7: MUL8 returns the unsigned product of the low 8 bits of the two operands, zero-extended to 32 bits.
- R8: MIN and MAX select by unsigned comparison. CMP returns 1 when the operands are equal, 2 when the first is greater and 4 when the first is less (unsigned).
- R9: In the immediate form MOVI returns `imm` shifted left by `mov_shift`, and bits above bit 31 are dropped. In the two-register form MOVI returns 0.
- R10: In the two-register form MSB returns the index of the highest set bit of `src2`, and `src2` of 0 returns 0. In the immediate form MSB returns 0.
- R11: NOP and every code not listed in R1 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset of the carry flag |
| in_valid | input | 1 | An instruction is issued this cycle; enables the flag update |
| two_reg | input | 1 | 1 selects the two-register form, 0 the immediate form |
| hdr_opc | input | 5 | Operation code from the header (immediate form) |
| sub_opc | input | 5 | Operation selector field (two-register form) |
| src1 | input | 32 | First register operand |
| src2 | input | 32 | Second register operand |
| imm | input | 16 | Unsigned immediate |
| mov_shift | input | 5 | Left shift applied to the immediate by MOVI |
| result | output | 32 | Combinational result |
| carry | output | 1 | Stored carry/borrow |

## Verification
The hardest case is the chained high-word operation, whose result depends on a flag written one or more instructions earlier. The bench first issues a low-word ADD or SUB that forces the carry or borrow to a chosen value. It then issues ADDHI or SUBHI on the very next cycle and checks that result and the new flag together. Other cases cover the high word itself overflowing, the flag surviving idle cycles and unrelated operations, and reset clearing it in the middle of a chain. The MSB boundaries of 0, 1 and bit 31 are checked in both forms.

// File: rtl/cpalu_pkg.sv
package cpalu_pkg;

  localparam int CP_XLEN  = 32;
  localparam int CP_OPC_W = 5;
  localparam int CP_SH_W  = $clog2(CP_XLEN);

  typedef enum logic [CP_OPC_W-1:0] {
    OP_NOP   = 5'h00,
    OP_ADD   = 5'h01,
    OP_ADDHI = 5'h02,
    OP_SUB   = 5'h03,
    OP_SUBHI = 5'h04,
    OP_AND   = 5'h05,
    OP_OR    = 5'h06,
    OP_XOR   = 5'h07,
    OP_NOT   = 5'h08,
    OP_SHL   = 5'h09,
    OP_USHR  = 5'h0a,
    OP_ISHR  = 5'h0b,
    OP_ROT   = 5'h0c,
    OP_MUL8  = 5'h0d,
    OP_MIN   = 5'h0e,
    OP_MAX   = 5'h0f,
    OP_CMP   = 5'h10,
    OP_MOVI  = 5'h11,
    OP_MSB   = 5'h14
  } cp_op_e;

  // index of highest set bit; zero input reports 0
  function automatic logic [CP_SH_W-1:0] f_msb_index(input logic [CP_XLEN-1:0] v);
    logic [CP_SH_W-1:0] idx;
    idx = '0;
    for (int i = 0; i < CP_XLEN; i++) begin
      if (v[i]) idx = i[CP_SH_W-1:0];
    end
    return idx;
  endfunction

  // left rotate with wrap into the low end
  function automatic logic [CP_XLEN-1:0] f_rotl(input logic [CP_XLEN-1:0] v,
                                                input logic [CP_SH_W-1:0] s);
    logic [2*CP_XLEN-1:0] dbl;
    dbl = {v, v} << s;
    return dbl[2*CP_XLEN-1:CP_XLEN];
  endfunction

  // three-way unsigned comparison code: 1 equal, 2 greater, 4 less
  function automatic logic [2:0] f_cmp_code(input logic [CP_XLEN-1:0] a,
                                            input logic [CP_XLEN-1:0] b);
    if (a == b)     return 3'b001;
    else if (a > b) return 3'b010;
    else            return 3'b100;
  endfunction

  function automatic logic f_is_flag_op(input logic [CP_OPC_W-1:0] op);
    return (op == OP_ADD) || (op == OP_ADDHI) || (op == OP_SUB) || (op == OP_SUBHI);
  endfunction

endpackage

// File: rtl/cpalu_operand_sel.sv
module cpalu_operand_sel
  import cpalu_pkg::*;
#(
  parameter int DATA_W = CP_XLEN,
  parameter int IMM_W  = 16,
  parameter int OPC_W  = CP_OPC_W
) (
  input  logic              two_reg,
  input  logic [OPC_W-1:0]  hdr_opc,
  input  logic [OPC_W-1:0]  sub_opc,
  input  logic [DATA_W-1:0] src2,
  input  logic [IMM_W-1:0]  imm,
  output logic [OPC_W-1:0]  eff_op,
  output logic [DATA_W-1:0] opb
);

  localparam int PAD_W = DATA_W - IMM_W;

  logic [DATA_W-1:0] imm_ext;

  assign imm_ext = {{PAD_W{1'b0}}, imm};

  always_comb begin
    if (two_reg) begin
      eff_op = sub_opc;
      opb    = src2;
    end else begin
      eff_op = hdr_opc;
      opb    = imm_ext;
    end
  end

endmodule

// File: rtl/cpalu_arith.sv
module cpalu_arith
  import cpalu_pkg::*;
#(
  parameter int DATA_W = CP_XLEN,
  parameter int OPC_W  = CP_OPC_W,
  parameter int MUL_W  = 8
) (
  input  logic [OPC_W-1:0]  op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              carry_in,
  output logic [DATA_W-1:0] res,
  output logic              carry_next,
  output logic              is_arith
);

  localparam int PROD_W = 2 * MUL_W;
  localparam int EXT_W  = DATA_W + 1;

  logic [EXT_W-1:0]  sum_lo;
  logic [EXT_W-1:0]  sum_hi;
  logic [EXT_W-1:0]  dif_lo;
  logic [EXT_W-1:0]  dif_hi;
  logic [PROD_W-1:0] prod;
  logic [2:0]        cmp_code;
  logic [EXT_W-1:0]  cin_ext;

  assign cin_ext  = {{DATA_W{1'b0}}, carry_in};
  assign sum_lo   = {1'b0, a} + {1'b0, b};
  assign sum_hi   = {1'b0, a} + {1'b0, b} + cin_ext;
  assign dif_lo   = {1'b0, a} - {1'b0, b};
  assign dif_hi   = {1'b0, a} - {1'b0, b} - cin_ext;
  assign prod     = {{MUL_W{1'b0}}, a[MUL_W-1:0]} * {{MUL_W{1'b0}}, b[MUL_W-1:0]};
  assign cmp_code = f_cmp_code(a, b);

  always_comb begin
    res        = '0;
    carry_next = carry_in;
    is_arith   = 1'b1;
    case (op)
      OP_ADD: begin
        res        = sum_lo[DATA_W-1:0];
        carry_next = sum_lo[DATA_W];
      end
      OP_ADDHI: begin
        res        = sum_hi[DATA_W-1:0];
        carry_next = sum_hi[DATA_W];
      end
      OP_SUB: begin
        res        = dif_lo[DATA_W-1:0];
        carry_next = dif_lo[DATA_W];
      end
      OP_SUBHI: begin
        res        = dif_hi[DATA_W-1:0];
        carry_next = dif_hi[DATA_W];
      end
      OP_MUL8: res = {{(DATA_W-PROD_W){1'b0}}, prod};
      OP_MIN:  res = (a < b) ? a : b;
      OP_MAX:  res = (a > b) ? a : b;
      OP_CMP:  res = {{(DATA_W-3){1'b0}}, cmp_code};
      default: is_arith = 1'b0;
    endcase
  end

endmodule

// File: rtl/cpalu_bitops.sv
module cpalu_bitops
  import cpalu_pkg::*;
#(
  parameter int DATA_W = CP_XLEN,
  parameter int IMM_W  = 16,
  parameter int OPC_W  = CP_OPC_W,
  parameter int SH_W   = CP_SH_W
) (
  input  logic              two_reg,
  input  logic [OPC_W-1:0]  op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [IMM_W-1:0]  imm,
  input  logic [SH_W-1:0]   mov_shift,
  output logic [DATA_W-1:0] res
);

  logic [SH_W-1:0]   amt;
  logic [DATA_W-1:0] movi_val;
  logic [SH_W-1:0]   msb_idx;

  assign amt      = b[SH_W-1:0];
  assign movi_val = {{(DATA_W-IMM_W){1'b0}}, imm} << mov_shift;
  assign msb_idx  = f_msb_index(b);

  always_comb begin
    res = '0;
    case (op)
      OP_AND:  res = a & b;
      OP_OR:   res = a | b;
      OP_XOR:  res = a ^ b;
      OP_NOT:  res = ~b;
      OP_SHL:  res = a << amt;
      OP_USHR: res = a >> amt;
      OP_ISHR: res = $unsigned($signed(a) >>> amt);
      OP_ROT:  res = f_rotl(a, amt);
      OP_MOVI: res = two_reg ? '0 : movi_val;
      OP_MSB:  res = two_reg ? {{(DATA_W-SH_W){1'b0}}, msb_idx} : '0;
      default: res = '0;
    endcase
  end

endmodule

// File: rtl/cpalu_carry_reg.sv
module cpalu_carry_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic we,
  input  logic d,
  output logic q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= 1'b0;
    else if (we) q <= d;
  end

endmodule

// File: rtl/cpalu_core.sv
module cpalu_core
  import cpalu_pkg::*;
#(
  parameter int DATA_W = CP_XLEN,
  parameter int IMM_W  = 16,
  parameter int OPC_W  = CP_OPC_W,
  parameter int MUL_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              two_reg,
  input  logic [OPC_W-1:0]  hdr_opc,
  input  logic [OPC_W-1:0]  sub_opc,
  input  logic [DATA_W-1:0] src1,
  input  logic [DATA_W-1:0] src2,
  input  logic [IMM_W-1:0]  imm,
  input  logic [4:0]        mov_shift,
  output logic [DATA_W-1:0] result,
  output logic              carry
);

  localparam int SH_W = $clog2(DATA_W);

  logic [OPC_W-1:0]  eff_op;
  logic [DATA_W-1:0] opb;
  logic [DATA_W-1:0] arith_res;
  logic [DATA_W-1:0] bit_res;
  logic              arith_sel;
  logic              carry_next;
  logic              flag_we;

  cpalu_operand_sel #(.DATA_W(DATA_W), .IMM_W(IMM_W), .OPC_W(OPC_W)) u_sel (
    .two_reg (two_reg),
    .hdr_opc (hdr_opc),
    .sub_opc (sub_opc),
    .src2    (src2),
    .imm     (imm),
    .eff_op  (eff_op),
    .opb     (opb)
  );

  cpalu_arith #(.DATA_W(DATA_W), .OPC_W(OPC_W), .MUL_W(MUL_W)) u_arith (
    .op         (eff_op),
    .a          (src1),
    .b          (opb),
    .carry_in   (carry),
    .res        (arith_res),
    .carry_next (carry_next),
    .is_arith   (arith_sel)
  );

  cpalu_bitops #(.DATA_W(DATA_W), .IMM_W(IMM_W), .OPC_W(OPC_W), .SH_W(SH_W)) u_bits (
    .two_reg   (two_reg),
    .op        (eff_op),
    .a         (src1),
    .b         (opb),
    .imm       (imm),
    .mov_shift (mov_shift[SH_W-1:0]),
    .res       (bit_res)
  );

  assign flag_we = in_valid && f_is_flag_op(eff_op);
  assign result  = arith_sel ? arith_res : bit_res;

  cpalu_carry_reg u_flag (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (flag_we),
    .d     (carry_next),
    .q     (carry)
  );

endmodule

// File: rtl/cpalu_core_chk.sv
module cpalu_core_chk
  import cpalu_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        two_reg,
  input logic [4:0]  eff_op,
  input logic [31:0] opb,
  input logic [31:0] src1,
  input logic [31:0] src2,
  input logic [31:0] result,
  input logic        carry
);

  AST_FLAG_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(carry)); // R4

  AST_FLAG_OTHER_OP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !f_is_flag_op(eff_op)) |=> $stable(carry)); // R4

  AST_ADD_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && eff_op == OP_ADD) |=> (carry == $past(result < src1))); // R2

  AST_SUB_BORROW: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && eff_op == OP_SUB) |=> (carry == $past(src1 < opb))); // R2

  AST_NOT_IGNORES_A: assert property (@(posedge clk) disable iff (!rst_n)
    (two_reg && eff_op == OP_NOT) |-> (result == ~src2)); // R5

  AST_MUL8_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    (eff_op == OP_MUL8) |-> (result[31:16] == 16'h0)); // R7

  AST_CMP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    (eff_op == OP_CMP) |-> ($countones(result) == 1)); // R8

  AST_MSB_TOPBIT: assert property (@(posedge clk) disable iff (!rst_n)
    (two_reg && eff_op == OP_MSB && src2 > 32'd1) |-> ((src2 >> result) == 32'd1)); // R10

  AST_NOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (eff_op == OP_NOP) |-> (result == 32'h0)); // R11

endmodule

bind cpalu_core cpalu_core_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .two_reg  (two_reg),
  .eff_op   (eff_op),
  .opb      (opb),
  .src1     (src1),
  .src2     (src2),
  .result   (result),
  .carry    (carry)
);

// File: tb/tb_cpalu_core.sv
`timescale 1ns/1ps
module tb_cpalu_core;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        two_reg = 1'b0;
  logic [4:0]  hdr_opc = '0;
  logic [4:0]  sub_opc = '0;
  logic [31:0] src1 = '0;
  logic [31:0] src2 = '0;
  logic [15:0] imm = '0;
  logic [4:0]  mov_shift = '0;
  logic [31:0] result;
  logic        carry;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  cpalu_core dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .two_reg(two_reg),
    .hdr_opc(hdr_opc), .sub_opc(sub_opc), .src1(src1), .src2(src2),
    .imm(imm), .mov_shift(mov_shift), .result(result), .carry(carry)
  );

  typedef struct packed {
    logic        form2;
    logic [4:0]  opc;
    logic [31:0] a;
    logic [31:0] b;
    logic [15:0] im;
    logic [4:0]  sh;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 30;
  localparam vec_t VEC [0:NV-1] = '{
    '{1'b0, 5'h01, 32'h0000_0010, 32'h0, 16'h0005, 5'd0, 32'h0000_0015},   // R1 R2 imm add
    '{1'b1, 5'h01, 32'hFFFF_FFFF, 32'h2, 16'h0,    5'd0, 32'h0000_0001},   // R2 wrap
    '{1'b0, 5'h03, 32'h0000_0010, 32'h0, 16'h0020, 5'd0, 32'hFFFF_FFF0},   // R2 sub
    '{1'b1, 5'h05, 32'hF0F0_1234, 32'h0FF0_FF00, 16'h0, 5'd0, 32'h00F0_1200}, // R5
    '{1'b0, 5'h06, 32'h1200_0000, 32'h0, 16'h00AB, 5'd0, 32'h1200_00AB},   // R5 R1
    '{1'b1, 5'h07, 32'hFFFF_0000, 32'hFF00_FF00, 16'h0, 5'd0, 32'h00FF_FF00}, // R5
    '{1'b1, 5'h08, 32'hDEAD_BEEF, 32'h0000_FFFF, 16'h0, 5'd0, 32'hFFFF_0000}, // R5 not
    '{1'b0, 5'h08, 32'h0000_1234, 32'h0, 16'h00FF, 5'd0, 32'hFFFF_FF00},   // R5 not imm
    '{1'b1, 5'h09, 32'h0000_0003, 32'h0000_0024, 16'h0, 5'd0, 32'h0000_0030}, // R6 low5
    '{1'b1, 5'h0a, 32'h8000_0000, 32'h0000_001F, 16'h0, 5'd0, 32'h0000_0001}, // R6
    '{1'b1, 5'h0b, 32'h8000_0000, 32'h0000_0004, 16'h0, 5'd0, 32'hF800_0000}, // R6
    '{1'b1, 5'h0c, 32'h8000_0001, 32'h0000_0001, 16'h0, 5'd0, 32'h0000_0003}, // R6 rot
    '{1'b0, 5'h0c, 32'h1234_5678, 32'h0, 16'h0010, 5'd0, 32'h5678_1234},   // R6 rot imm
    '{1'b1, 5'h0d, 32'h0000_01FF, 32'h0000_03FF, 16'h0, 5'd0, 32'h0000_FE01}, // R7
    '{1'b1, 5'h0e, 32'hFFFF_FFFF, 32'h0000_0001, 16'h0, 5'd0, 32'h0000_0001}, // R8 min
    '{1'b1, 5'h0f, 32'hFFFF_FFFF, 32'h0000_0001, 16'h0, 5'd0, 32'hFFFF_FFFF}, // R8 max
    '{1'b1, 5'h10, 32'h0000_0005, 32'h0000_0005, 16'h0, 5'd0, 32'h0000_0001}, // R8 eq
    '{1'b1, 5'h10, 32'h8000_0000, 32'h0000_0001, 16'h0, 5'd0, 32'h0000_0002}, // R8 gt
    '{1'b0, 5'h10, 32'h0000_0003, 32'h0, 16'h0007, 5'd0, 32'h0000_0004},   // R8 lt
    '{1'b0, 5'h11, 32'h0000_FFFF, 32'h0, 16'hABCD, 5'd8, 32'h00AB_CD00},   // R9
    '{1'b0, 5'h11, 32'h0, 32'h0, 16'hABCD, 5'd24, 32'hCD00_0000},          // R9 drop
    '{1'b1, 5'h11, 32'h1, 32'h1, 16'hABCD, 5'd4, 32'h0},                   // R9 reg form
    '{1'b1, 5'h14, 32'hFFFF_FFFF, 32'h0, 16'h0, 5'd0, 32'h0},              // R10 zero
    '{1'b1, 5'h14, 32'h0, 32'h0000_0001, 16'h0, 5'd0, 32'h0},              // R10 one
    '{1'b1, 5'h14, 32'h0, 32'h8000_0000, 16'h0, 5'd0, 32'h0000_001F},      // R10 top
    '{1'b1, 5'h14, 32'h0, 32'h0000_0300, 16'h0, 5'd0, 32'h0000_0009},      // R10
    '{1'b0, 5'h14, 32'h0, 32'h0, 16'h8000, 5'd0, 32'h0},                   // R10 imm form
    '{1'b1, 5'h00, 32'h1234_5678, 32'h1, 16'h1, 5'd1, 32'h0},              // R11 nop
    '{1'b0, 5'h12, 32'h1234_5678, 32'h0, 16'h1111, 5'd0, 32'h0},           // R11 undef
    '{1'b1, 5'h1F, 32'h1234_5678, 32'h5, 16'h0, 5'd0, 32'h0}               // R11 undef
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic v, input logic f2, input logic [4:0] opc,
                       input logic [31:0] a, input logic [31:0] b,
                       input logic [15:0] im, input logic [4:0] sh);
    @(negedge clk);
    in_valid  = v;
    two_reg   = f2;
    hdr_opc   = f2 ? 5'h1F : opc;
    sub_opc   = f2 ? opc : 5'h1F;
    src1      = a;
    src2      = b;
    imm       = im;
    mov_shift = sh;
    #1;
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R4 reset carry", {31'b0, carry}, 32'h0);
    rst_n = 1'b1;

    // table walk with in_valid low: results only
    for (int i = 0; i < NV; i++) begin
      issue(1'b0, VEC[i].form2, VEC[i].opc, VEC[i].a, VEC[i].b, VEC[i].im, VEC[i].sh);
      chk($sformatf("R1 vec %0d op %h", i, VEC[i].opc), result, VEC[i].exp);
    end
    chk("R4 idle table kept carry", {31'b0, carry}, 32'h0);

    // R2/R3 64-bit add: low word carries out
    issue(1'b1, 1'b1, 5'h01, 32'hFFFF_FFFF, 32'h1, 16'h0, 5'd0);
    chk("R2 add low", result, 32'h0);
    issue(1'b1, 1'b1, 5'h02, 32'h1, 32'h2, 16'h0, 5'd0);
    chk("R2 add carry set", {31'b0, carry}, 32'h1);
    chk("R3 addhi uses carry", result, 32'h4);
    // high word itself overflows
    issue(1'b1, 1'b1, 5'h02, 32'hFFFF_FFFF, 32'h1, 16'h0, 5'd0);
    chk("R3 addhi cleared carry", {31'b0, carry}, 32'h0);
    chk("R3 addhi wrap", result, 32'h0);
    issue(1'b1, 1'b0, 5'h02, 32'h0, 32'h0, 16'h0, 5'd0);
    chk("R3 addhi carry out", {31'b0, carry}, 32'h1);
    chk("R3 addhi imm form", result, 32'h1);

    // subtract chain
    issue(1'b1, 1'b1, 5'h03, 32'h5, 32'h6, 16'h0, 5'd0);
    chk("R2 sub low", result, 32'hFFFF_FFFF);
    issue(1'b1, 1'b1, 5'h04, 32'hA, 32'h3, 16'h0, 5'd0);
    chk("R2 sub borrow set", {31'b0, carry}, 32'h1);
    chk("R3 subhi uses borrow", result, 32'h6);
    issue(1'b1, 1'b1, 5'h03, 32'h0, 32'h1, 16'h0, 5'd0);
    chk("R3 subhi cleared borrow", {31'b0, carry}, 32'h0);
    issue(1'b1, 1'b1, 5'h04, 32'h0, 32'h0, 16'h0, 5'd0);
    chk("R3 subhi borrow chain", result, 32'hFFFF_FFFF);
    issue(1'b0, 1'b1, 5'h00, 32'h0, 32'h0, 16'h0, 5'd0);
    chk("R3 subhi borrow out", {31'b0, carry}, 32'h1);

    // flag holds: other op valid, then add with valid low
    issue(1'b1, 1'b1, 5'h05, 32'hFFFF_FFFF, 32'h0, 16'h0, 5'd0);
    issue(1'b0, 1'b1, 5'h01, 32'h1, 32'h1, 16'h0, 5'd0);
    chk("R4 other op kept carry", {31'b0, carry}, 32'h1);
    issue(1'b0, 1'b1, 5'h00, 32'h0, 32'h0, 16'h0, 5'd0);
    chk("R4 invalid add kept carry", {31'b0, carry}, 32'h1);

    // reset in the middle of a chain
    rst_n = 1'b0;
    #1;
    chk("R4 reset clears carry", {31'b0, carry}, 32'h0);
    issue(1'b0, 1'b1, 5'h02, 32'h0, 32'h0, 16'h0, 5'd0);
    chk("R3 addhi after reset", result, 32'h0);
    rst_n = 1'b1;

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule